// File: doc/BRIEF.md
# SEC-DED Codec with Odd-Weight Check Columns

This block pairs a combinational encoder with a registered decoder for a single-error-correcting, double-error-detecting linear block code. The encoder appends R check bits to K data bits and produces an N = K + R bit systematic code word. The data occupies the low K bits and the check bits the high R bits. The decoder recomputes the check bits from a received word and XORs them with the stored ones to form an R-bit syndrome. It then repairs a single flipped bit, or flags the word as beyond repair.

Every column of the check matrix is distinct, nonzero and of odd weight. The R check-bit columns are the unit vectors. The K data columns are odd-weight vectors of weight three or more, taken in rising weight and then rising value. With these columns, the parity of the syndrome alone tells a single error from a double error, and no extra overall parity bit is needed. The default is the (8,4) code. Setting K=64, R=8 builds the shortened (72,64) code from the lowest-weight columns.

Top module: `secded_codec`

## Requirements
- R1: `enc_word[K-1:0]` equals `enc_data` and check bit j equals the XOR of every data bit whose column has bit j set. For the default K=4, R=4 the data columns are 0111, 1011, 1101 and 1110 for data bits 0 to 3, so check bit j is the XOR of all data bits except bit 3-j.
- R2: A received word with zero syndrome returns its data bits unchanged, with both flags low.
- R3: A word with one flipped data bit returns the original data, with `dec_corrected` high and `dec_uncorrectable` low.
- R4: A word with one flipped check bit returns the data unchanged, with `dec_corrected` high and `dec_uncorrectable` low.
- R5: Any nonzero syndrome of even weight raises `dec_uncorrectable` and leaves `dec_corrected` low. This covers every two-bit error. The same applies to an odd-weight syndrome that matches no column.
- R6: `dec_valid_out` follows `dec_valid_in` one clock later. The decoded data and the flags update only on cycles where `dec_valid_in` is high, and hold otherwise.
- R7: While `rst_n` is low, `dec_valid_out`, `dec_data` and both flags are zero.
- R8: `dec_corrected` and `dec_uncorrectable` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data | input | K | Data word to encode |
| enc_word | output | N | Systematic code word, checks in high bits |
| dec_valid_in | input | 1 | Received word is valid this cycle |
| dec_word | input | N | Received, possibly corrupted code word |
| dec_valid_out | output | 1 | Decoder results valid |
| dec_data | output | K | Corrected data |
| dec_corrected | output | 1 | A single-bit error was repaired |
| dec_uncorrectable | output | 1 | Error detected that cannot be repaired |

## Verification
The bench builds the default K=4, R=4 configuration, where the whole data space has only 16 values. This makes it practical to check every encoding and to apply, for every data value, the clean word, all 8 single-bit corruptions and all 28 two-bit corruptions. It also covers the hold behaviour while `dec_valid_in` is low and the reset state. In this configuration every odd syndrome matches a column, so the unmatched-odd path of R5 is only reachable with a wider configuration such as K=64, R=8.

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int K = 4,
  parameter int R = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [K-1:0]     enc_data,
  output logic [K+R-1:0]   enc_word,
  input  logic             dec_valid_in,
  input  logic [K+R-1:0]   dec_word,
  output logic             dec_valid_out,
  output logic [K-1:0]     dec_data,
  output logic             dec_corrected,
  output logic             dec_uncorrectable
);
  localparam int N = K + R;

  function automatic logic [R-1:0] col_of(input int idx);
    int cnt;
    cnt = 0;
    for (int w = 3; w <= R; w += 2)
      for (int v = 0; v < (1 << R); v++)
        if ($countones(v) == w) begin
          if (cnt == idx) return R'(v);
          cnt++;
        end
    return '0;
  endfunction

  logic [R-1:0] enc_term [K];
  logic [R-1:0] rx_term  [K];
  logic [K-1:0] flip;
  logic [R-1:0] enc_chk, rx_chk, syn;
  logic         single, unc;

  for (genvar gi = 0; gi < K; gi++) begin : g_col
    localparam logic [R-1:0] COL = col_of(gi);
    assign enc_term[gi] = {R{enc_data[gi]}} & COL;
    assign rx_term[gi]  = {R{dec_word[gi]}} & COL;
    assign flip[gi]     = (syn == COL);
  end

  always_comb begin
    enc_chk = '0;
    rx_chk  = '0;
    for (int i = 0; i < K; i++) begin
      enc_chk ^= enc_term[i];
      rx_chk  ^= rx_term[i];
    end
  end

  assign enc_word = {enc_chk, enc_data};
  assign syn      = dec_word[N-1:K] ^ rx_chk;
  assign single   = (^syn) && ((|flip) || $onehot(syn));
  assign unc      = (syn != '0) && !single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_out     <= 1'b0;
      dec_data          <= '0;
      dec_corrected     <= 1'b0;
      dec_uncorrectable <= 1'b0;
    end else begin
      dec_valid_out <= dec_valid_in;
      if (dec_valid_in) begin
        dec_data          <= dec_word[K-1:0] ^ flip;
        dec_corrected     <= single;
        dec_uncorrectable <= unc;
      end
    end
  end
endmodule

module secded_codec_chk #(
  parameter int K = 4,
  parameter int R = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dec_valid_in,
  input logic         dec_valid_out,
  input logic [K-1:0] dec_data,
  input logic         dec_corrected,
  input logic         dec_uncorrectable
);
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_corrected && dec_uncorrectable));

  assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_in |=> dec_valid_out);

  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_in |=> !dec_valid_out);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_in |=> ($stable(dec_data) && $stable(dec_corrected) && $stable(dec_uncorrectable)));

  assert_reset_state_R7: assert property (@(posedge clk)
    !rst_n |-> (!dec_valid_out && dec_data == '0 && !dec_corrected && !dec_uncorrectable));
endmodule

bind secded_codec secded_codec_chk #(.K(K), .R(R)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid_in(dec_valid_in),
  .dec_valid_out(dec_valid_out), .dec_data(dec_data),
  .dec_corrected(dec_corrected), .dec_uncorrectable(dec_uncorrectable)
);

// File: tb/secded_codec_tb.sv
module secded_codec_tb;
  localparam int K = 4;
  localparam int R = 4;
  localparam int N = K + R;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [K-1:0] enc_data;
  logic [N-1:0] enc_word;
  logic         dec_valid_in;
  logic [N-1:0] dec_word;
  logic         dec_valid_out;
  logic [K-1:0] dec_data;
  logic         dec_corrected;
  logic         dec_uncorrectable;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  secded_codec #(.K(K), .R(R)) u_dut (.*);

  function automatic logic [N-1:0] ref_encode(input logic [K-1:0] d);
    logic [R-1:0] c;
    for (int j = 0; j < R; j++) c[j] = ^(d & ~(4'b1 << (3 - j)));
    return {c, d};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic decode(input logic [N-1:0] w);
    @(negedge clk);
    dec_valid_in = 1'b1;
    dec_word     = w;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    dec_valid_in = 1'b0;
    dec_word = '0;
    enc_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check(!dec_valid_out && dec_data == '0 && !dec_corrected && !dec_uncorrectable,
          "R7 reset", {dec_valid_out, dec_data, dec_corrected, dec_uncorrectable}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int d = 0; d < 16; d++) begin
      enc_data = K'(d);
      #1;
      check(enc_word == ref_encode(K'(d)), "R1 encode", enc_word, ref_encode(K'(d)));
    end

    for (int d = 0; d < 16; d++) begin
      logic [N-1:0] cw;
      cw = ref_encode(K'(d));
      decode(cw);
      check(dec_valid_out && dec_data == K'(d) && !dec_corrected && !dec_uncorrectable,
            "R2 clean", {dec_valid_out, dec_data, dec_corrected, dec_uncorrectable},
            {1'b1, K'(d), 2'b00});
      for (int b = 0; b < N; b++) begin
        decode(cw ^ (N'(1) << b));
        check(dec_data == K'(d) && dec_corrected && !dec_uncorrectable,
              (b < K) ? "R3 data-bit single" : "R4 check-bit single",
              {dec_data, dec_corrected, dec_uncorrectable}, {K'(d), 2'b10});
      end
      for (int a = 0; a < N; a++)
        for (int b = a + 1; b < N; b++) begin
          decode(cw ^ (N'(1) << a) ^ (N'(1) << b));
          check(!dec_corrected && dec_uncorrectable,
                "R5 double R8", {dec_corrected, dec_uncorrectable}, 2'b01);
        end
    end

    decode(ref_encode(4'h9) ^ 8'h02);
    check(dec_data == 4'h9 && dec_corrected, "R3 before hold",
          {dec_data, dec_corrected}, {4'h9, 1'b1});
    @(negedge clk);
    dec_valid_in = 1'b0;
    dec_word = ref_encode(4'h6) ^ 8'h11;
    @(posedge clk);
    #1;
    check(!dec_valid_out && dec_data == 4'h9 && dec_corrected && !dec_uncorrectable,
          "R6 hold", {dec_valid_out, dec_data, dec_corrected, dec_uncorrectable},
          {1'b0, 4'h9, 2'b10});
    @(posedge clk);
    #1;
    check(!dec_valid_out && dec_data == 4'h9, "R6 hold second cycle",
          {dec_valid_out, dec_data}, {1'b0, 4'h9});

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule